// File: doc/BRIEF.md
# DDC EDID Read Engine

This block fetches display identification bytes over a two-wire DDC bus and stores them in a small receive FIFO. Host logic loads a packed address word, a byte count and a command code, then pulses a start request. The engine can first write a segment number to the segment-pointer device. It then writes the word offset to the EDID device and reads the requested bytes back after a repeated START. The bytes land in the FIFO in bus order. The start bit stays high for the whole transfer. When the transfer ends, a done flag or an error flag reports the outcome.

A full 128-byte block is fetched as a series of chunks of at most 16 bytes. The host advances the offset by the chunk length each time. An odd-numbered block begins at offset 128, and the segment is the block number shifted right by one. The bit clock comes from the system clock through a divider input. A bit lasts four quarter-phases of `clk_div + 1` cycles each, so a 50 MHz clock with `clk_div = 124` gives about 100 kHz. Both bus lines are open-drain: the block only ever pulls a line low.

Top module: `ddc_edid_reader`

## Requirements
- R1: After reset the start bit, soft-reset bit, done flag and error flag are low, the FIFO is empty, and neither bus line is pulled low.
- R2: An accepted request sets the start bit on the next clock. The bit stays high until the closing STOP has been driven and then clears. Done is set at that moment if the transfer succeeded.
- R3: The address word holds the segment in [31:24], the segment-pointer write byte in [23:16] (sent as given, nominally 0x60), the word offset in [15:8] and the 7-bit EDID device address in [7:0] (nominally 0x50). The device address goes on the wire as 0xA0 for the write and 0xA1 for the read.
- R4: When the segment is nonzero the bus sequence is: START, pointer byte, segment, repeated START, device write, offset, repeated START, device read. That is three START conditions in all. When the segment is zero, the pointer write is skipped and only two START conditions occur.
- R5: Exactly the requested number of bytes is read and pushed into the FIFO in bus order. Every byte except the last is acknowledged, the last is not acknowledged, and a STOP follows.
- R6: If the pointer, device-write or device-read address byte is not acknowledged, the engine sends a STOP and clears the start bit. It leaves done low, sets error, and adds no bytes to the FIFO.
- R7: A request is rejected when the command code is not 4 (the explicit-offset read), the byte count is 0 or above 16, or bit 7 of the device field is set. On rejection, error rises on the next clock, the start bit stays low and SCL is never driven.
- R8: While the enable input is low, a start request is ignored: the start bit, done and error keep their values and the bus stays idle.
- R9: A pulse on the FIFO clear input empties the receive FIFO.
- R10: A soft-reset request raises the soft-reset bit for exactly one clock. The reset aborts any transfer, releases both lines, clears done, error and the start bit, and empties the FIFO. The bit then clears by itself.
- R11: Consecutive SCL rising edges within a byte are 4*(clk_div+1) clocks apart. SDA changes only while SCL is low, except inside START and STOP conditions.
- R12: Accepting a new request clears the done and error flags left by the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Engine enable |
| start_req | input | 1 | One-cycle request to begin a transfer |
| srst_req | input | 1 | One-cycle soft-reset request |
| fifo_clr | input | 1 | One-cycle FIFO clear |
| cmd | input | 3 | Command code; 4 selects explicit-offset read |
| addr_word | input | 32 | Packed segment, pointer byte, offset, device address |
| byte_cnt | input | 5 | Bytes to read, 1 to 16 |
| clk_div | input | 16 | Quarter-bit divider; quarter = clk_div+1 clocks |
| rd_en | input | 1 | Pop one byte from the FIFO |
| sda_in | input | 1 | Sampled level of the SDA line |
| start_bit | output | 1 | High while a transfer runs |
| srst_bit | output | 1 | High while a soft reset is pending |
| done | output | 1 | Last transfer completed successfully |
| err | output | 1 | Last request was rejected or aborted |
| rd_data | output | 8 | Byte at the FIFO head |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_level | output | 5 | Number of bytes held in the FIFO |
| scl_lo | output | 1 | Pull SCL low when high |
| sda_lo | output | 1 | Pull SDA low when high |

## Verification
The hardest situation to reach is a soft reset in the middle of a read. At that point the target may be holding SDA low halfway through a data byte, and the FIFO is partly filled. The bench starts a 16-byte read, waits until bytes are flowing, and then issues the soft reset. It checks that the lines are released, the flags are cleared and the FIFO is empty. A further read then proves that the engine recovers. Refusals at address phases are produced by a target model that can be told to leave one chosen address byte unacknowledged. The pointer and device bytes are both made to fail this way.

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter logic [2:0] RD_CMD = 3'd4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_en,
  input  logic                     start_req,
  input  logic                     srst_req,
  input  logic                     fifo_clr,
  input  logic [2:0]               cmd,
  input  logic [31:0]              addr_word,
  input  logic [$clog2(DEPTH):0]   byte_cnt,
  input  logic [DIV_W-1:0]         clk_div,
  input  logic                     rd_en,
  input  logic                     sda_in,
  output logic                     start_bit,
  output logic                     srst_bit,
  output logic                     done,
  output logic                     err,
  output logic [7:0]               rd_data,
  output logic                     fifo_empty,
  output logic [$clog2(DEPTH):0]   fifo_level,
  output logic                     scl_lo,
  output logic                     sda_lo
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [2:0] {IDLE, START, TX, RX, STOP} state_t;
  typedef enum logic [2:0] {SEGP, SEGV, DEVW, OFFS, DEVR} stage_t;

  state_t state;
  stage_t stage;
  logic [DIV_W-1:0] div_cnt;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic [CW-1:0] left;
  logic nak, failed;
  logic [7:0] seg_q, segp_q, off_q;
  logic [6:0] dev_q;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] lvl;

  wire qtick  = (state != IDLE) && (div_cnt == clk_div);
  wire q_last = qtick && (q == 2'd3);
  wire q_samp = qtick && (q == 2'd2);
  wire go     = start_req && ctl_en && !start_bit && !srst_bit;
  wire req_ok = (cmd == RD_CMD) && (byte_cnt != '0) && (byte_cnt <= CW'(DEPTH)) && !addr_word[7];
  wire push   = q_last && (state == RX) && (bitn == 4'd7) && (lvl != CW'(DEPTH));
  wire pop    = rd_en && (lvl != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; stage <= DEVW; div_cnt <= '0; q <= '0; bitn <= '0; sh <= '0;
      left <= '0; nak <= 1'b0; failed <= 1'b0; seg_q <= '0; segp_q <= '0; off_q <= '0;
      dev_q <= '0; start_bit <= 1'b0; srst_bit <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else if (srst_bit) begin
      state <= IDLE; div_cnt <= '0; q <= '0; bitn <= '0; nak <= 1'b0; failed <= 1'b0;
      start_bit <= 1'b0; srst_bit <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      if (srst_req) srst_bit <= 1'b1;
      div_cnt <= (state == IDLE || qtick) ? '0 : div_cnt + 1'b1;
      if (qtick) q <= q + 1'b1;
      case (state)
        IDLE: if (go) begin
          done <= 1'b0;
          if (req_ok) begin
            start_bit <= 1'b1; err <= 1'b0; failed <= 1'b0;
            seg_q <= addr_word[31:24]; segp_q <= addr_word[23:16];
            off_q <= addr_word[15:8]; dev_q <= addr_word[6:0];
            left <= byte_cnt;
            stage <= (addr_word[31:24] != 8'd0) ? SEGP : DEVW;
            state <= START;
          end else begin
            err <= 1'b1;
          end
        end
        START: if (q_last) begin
          state <= TX; bitn <= '0;
          sh <= (stage == SEGP) ? segp_q : {dev_q, stage == DEVR};
        end
        TX: begin
          if (q_samp && bitn == 4'd8) nak <= sda_in;
          if (q_last) begin
            if (bitn != 4'd8) begin
              sh <= sh << 1; bitn <= bitn + 1'b1;
            end else begin
              bitn <= '0;
              if (nak && (stage inside {SEGP, DEVW, DEVR})) begin
                failed <= 1'b1; state <= STOP;
              end else begin
                case (stage)
                  SEGP:    begin stage <= SEGV; sh <= seg_q; end
                  SEGV:    begin stage <= DEVW; state <= START; end
                  DEVW:    begin stage <= OFFS; sh <= off_q; end
                  OFFS:    begin stage <= DEVR; state <= START; end
                  default: state <= RX;
                endcase
              end
            end
          end
        end
        RX: begin
          if (q_samp && bitn != 4'd8) sh <= {sh[6:0], sda_in};
          if (q_last) begin
            if (bitn != 4'd8) bitn <= bitn + 1'b1;
            else begin
              bitn <= '0; left <= left - 1'b1;
              if (left == CW'(1)) state <= STOP;
            end
          end
        end
        STOP: if (q_last) begin
          state <= IDLE; start_bit <= 1'b0; done <= !failed; err <= failed;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else if (srst_bit || fifo_clr) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      lvl <= lvl + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= sh;

  assign rd_data    = mem[rp];
  assign fifo_empty = (lvl == '0);
  assign fifo_level = lvl;

  always_comb begin
    scl_lo = 1'b0;
    sda_lo = 1'b0;
    case (state)
      START: begin scl_lo = (q == 2'd0) || (q == 2'd3); sda_lo = q[1]; end
      TX:    begin scl_lo = (q == 2'd0) || (q == 2'd3); sda_lo = (bitn != 4'd8) && !sh[7]; end
      RX:    begin scl_lo = (q == 2'd0) || (q == 2'd3); sda_lo = (bitn == 4'd8) && (left != CW'(1)); end
      STOP:  begin scl_lo = (q == 2'd0); sda_lo = !q[1]; end
      default: ;
    endcase
  end

  // R1
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_bit |-> (!scl_lo && !sda_lo));
  // R2
  finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_bit) && !$past(srst_bit)) |-> (done != err));
  // R4
  seg_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX && stage == SEGP) |-> (seg_q != 8'd0));
  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));
  // R7
  bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !req_ok && !srst_req) |=> (err && !start_bit));
  // R10
  srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_bit |=> (!srst_bit && !start_bit && fifo_empty && !done && !err));
  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo && $past(!scl_lo) && (state == TX || state == RX) && $past(state) == state)
      |-> $stable(sda_lo));
endmodule

// File: tb/ddc_edid_reader_bench.sv
module ddc_edid_reader_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_en = 1'b0, start_req = 1'b0, srst_req = 1'b0, fifo_clr = 1'b0, rd_en = 1'b0;
  logic [2:0] cmd = 3'd4;
  logic [31:0] addr_word = '0;
  logic [4:0] byte_cnt = '0;
  logic [15:0] clk_div = 16'd1;
  logic start_bit, srst_bit, done, err, fifo_empty, scl_lo, sda_lo;
  logic [7:0] rd_data;
  logic [4:0] fifo_level;
  logic s_sda_lo = 1'b0;
  wire scl = !scl_lo;
  wire sda = !(sda_lo || s_sda_lo);

  int checks = 0, errors = 0;
  longint cyc = 0;
  byte unsigned exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  ddc_edid_reader u_ddc_edid_reader (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .start_req(start_req), .srst_req(srst_req),
    .fifo_clr(fifo_clr), .cmd(cmd), .addr_word(addr_word), .byte_cnt(byte_cnt),
    .clk_div(clk_div), .rd_en(rd_en), .sda_in(sda), .start_bit(start_bit),
    .srst_bit(srst_bit), .done(done), .err(err), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_level(fifo_level), .scl_lo(scl_lo), .sda_lo(sda_lo));

  task automatic chk_eq(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic byte unsigned edid_b(input int s, input int p);
    return byte'((s * 29 + p * 7 + 17) & 255);
  endfunction

  // target model on the bus
  bit scl_p = 1'b1, sda_p = 1'b1, first = 1'b0, mack = 1'b0;
  int mode = 0, bitc = 0, kind = 0;
  int starts = 0, stops = 0, segw = 0, scl_falls = 0, nack_byte = -1;
  longint last_rise = 0, last_per = 0;
  byte unsigned shreg = 0, txb = 0, ptr = 0, seg = 0;

  always @(negedge clk) begin
    bit sn, dn;
    cyc++;
    sn = scl; dn = sda;
    if (!rst_n) begin
      mode = 0; s_sda_lo = 1'b0; seg = 0;
    end else if (sn && scl_p && sda_p && !dn) begin
      mode = 1; bitc = 0; first = 1'b1; s_sda_lo = 1'b0; starts++;
    end else if (sn && scl_p && !sda_p && dn) begin
      mode = 0; s_sda_lo = 1'b0; seg = 0; stops++;
    end else if (sn && !scl_p) begin
      if (mode == 1 && bitc >= 1) last_per = cyc - last_rise;
      last_rise = cyc;
      if (mode == 1 && bitc < 8) begin shreg = {shreg[6:0], dn}; bitc++; end
      else if (mode == 4) mack = !dn;
    end else if (!sn && scl_p) begin
      scl_falls++;
      case (mode)
        1: if (bitc == 8) begin
          if (first) begin
            first = 1'b0;
            if (int'(shreg) == nack_byte || !(shreg inside {8'h60, 8'hA0, 8'hA1})) mode = 0;
            else begin
              kind = (shreg == 8'h60) ? 1 : (shreg == 8'hA0) ? 2 : 3;
              if (kind == 1) segw++;
              mode = 2; s_sda_lo = 1'b1;
            end
          end else begin
            if (kind == 1) seg = shreg; else if (kind == 2) ptr = shreg;
            mode = 2; s_sda_lo = 1'b1;
          end
        end
        2: begin
          s_sda_lo = 1'b0; bitc = 0;
          if (kind == 3) begin
            txb = edid_b(seg, ptr); ptr++; s_sda_lo = !txb[7]; bitc = 1; mode = 3;
          end else mode = 1;
        end
        3: if (bitc < 8) begin s_sda_lo = !txb[7 - bitc]; bitc++; end
           else begin s_sda_lo = 1'b0; mode = 4; end
        4: if (mack) begin
             txb = edid_b(seg, ptr); ptr++; s_sda_lo = !txb[7]; bitc = 1; mode = 3;
           end else mode = 0;
        default: ;
      endcase
    end
    scl_p = sn; sda_p = dn;
  end

  // scoreboard monitor: compares each popped byte with the queue head
  always @(negedge clk) begin
    if (rst_n && rd_en && !fifo_empty) begin
      if (exp_q.size() == 0) chk_eq("R5 unexpected fifo byte", rd_data, -1);
      else chk_eq("R5 fifo data order", rd_data, exp_q.pop_front());
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic drain;
    while (!fifo_empty) begin
      tick; rd_en = 1'b1;
      tick; rd_en = 1'b0;
    end
    chk_eq("R5 all expected bytes seen", exp_q.size(), 0);
  endtask

  task automatic do_read(input int sg, input int off, input int cnt, input bit ok, input bit keep);
    int s0, w0;
    s0 = starts; w0 = segw;
    if (ok) for (int i = 0; i < cnt; i++) exp_q.push_back(edid_b(sg, (off + i) & 255));
    tick; addr_word = {8'(sg), 8'h60, 8'(off), 8'h50}; byte_cnt = 5'(cnt); start_req = 1'b1;
    tick; start_req = 1'b0;
    @(negedge clk);
    chk_eq("R2 start bit set", start_bit, 1);
    chk_eq("R12 done cleared on accept", done, 0);
    chk_eq("R12 err cleared on accept", err, 0);
    while (start_bit) @(negedge clk);
    chk_eq("R2 done at end", done, ok);
    chk_eq("R6 err at end", err, !ok);
    if (ok) begin
      chk_eq("R5 fifo level", fifo_level, cnt);
      chk_eq("R3 R4 segment pointer writes", segw - w0, (sg != 0) ? 1 : 0);
      chk_eq("R4 start conditions", starts - s0, (sg != 0) ? 3 : 2);
    end else begin
      chk_eq("R6 no bytes on abort", fifo_level, 0);
    end
    if (!keep) drain;
  endtask

  task automatic bad_req(input logic [2:0] c, input logic [4:0] n, input logic [7:0] dev, input string req);
    int f0;
    tick; cmd = c; byte_cnt = n; addr_word = {8'h00, 8'h60, 8'h00, dev}; start_req = 1'b1;
    tick; start_req = 1'b0; f0 = scl_falls;
    @(negedge clk);
    chk_eq({req, " err"}, err, 1);
    chk_eq({req, " start bit"}, start_bit, 0);
    repeat (20) @(negedge clk);
    chk_eq({req, " no scl"}, scl_falls - f0, 0);
    tick; cmd = 3'd4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    chk_eq("R1 start bit", start_bit, 0);
    chk_eq("R1 srst bit", srst_bit, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 err", err, 0);
    chk_eq("R1 fifo empty", fifo_empty, 1);
    chk_eq("R1 lines released", {scl_lo, sda_lo}, 0);
    tick; rst_n = 1'b1; ctl_en = 1'b1;

    do_read(0, 0, 16, 1'b1, 1'b0);
    do_read(1, 128, 16, 1'b1, 1'b0);
    do_read(2, 5, 1, 1'b1, 1'b0);

    tick; clk_div = 16'd2;
    do_read(0, 32, 3, 1'b1, 1'b0);
    chk_eq("R11 scl period", last_per, 12);
    tick; clk_div = 16'd1;
    do_read(0, 48, 2, 1'b1, 1'b0);
    chk_eq("R11 scl period div1", last_per, 8);

    nack_byte = 8'hA0;
    do_read(0, 0, 4, 1'b0, 1'b0);
    nack_byte = 8'hA1;
    do_read(0, 0, 4, 1'b0, 1'b0);
    nack_byte = 8'h60;
    do_read(3, 0, 4, 1'b0, 1'b0);
    nack_byte = -1;
    do_read(0, 16, 2, 1'b1, 1'b0);

    bad_req(3'd3, 5'd4, 8'h50, "R7 bad command");
    bad_req(3'd4, 5'd0, 8'h50, "R7 zero count");
    bad_req(3'd4, 5'd17, 8'h50, "R7 count above 16");
    bad_req(3'd4, 5'd4, 8'hD0, "R7 device bit7");

    tick; ctl_en = 1'b0; addr_word = 32'h0060_0050; byte_cnt = 5'd4; start_req = 1'b1;
    tick; start_req = 1'b0; f0 = scl_falls;
    repeat (20) @(negedge clk);
    chk_eq("R8 start ignored", start_bit, 0);
    chk_eq("R8 err kept", err, 1);
    chk_eq("R8 done kept", done, 0);
    chk_eq("R8 bus idle", scl_falls - f0, 0);
    tick; ctl_en = 1'b1;

    do_read(1, 0, 6, 1'b1, 1'b1);
    tick; fifo_clr = 1'b1;
    tick; fifo_clr = 1'b0;
    @(negedge clk);
    chk_eq("R9 fifo emptied", fifo_empty, 1);
    chk_eq("R9 level zero", fifo_level, 0);
    exp_q.delete();

    tick; addr_word = 32'h0160_0050; byte_cnt = 5'd16; start_req = 1'b1;
    tick; start_req = 1'b0;
    repeat (400) @(negedge clk);
    chk_eq("R10 mid transfer", start_bit, 1);
    tick; srst_req = 1'b1;
    tick; srst_req = 1'b0;
    @(negedge clk);
    chk_eq("R10 srst bit high", srst_bit, 1);
    @(negedge clk);
    chk_eq("R10 srst bit cleared", srst_bit, 0);
    chk_eq("R10 start bit cleared", start_bit, 0);
    chk_eq("R10 lines released", {scl_lo, sda_lo}, 0);
    chk_eq("R10 fifo emptied", fifo_empty, 1);
    chk_eq("R10 flags cleared", {done, err}, 0);
    mode = 0; s_sda_lo = 1'b0; seg = 0;
    exp_q.delete();
    repeat (4) @(negedge clk);
    do_read(0, 64, 8, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule